// File: doc/BRIEF.md
# SPI Status Flags with Two-Step Clearing

This block keeps the status register of a byte-wide SPI peripheral. The register holds three sticky flags: transfer complete, write collision and mode fault. The shift engine sets the first one when a byte finishes. A data-register write made while a transfer is running sets the second. The third is set when slave-select is pulled low while the peripheral is configured as master. The block also produces the interrupt request and a write-inhibit level. That level gates the data-register load enable, so no new data is accepted while an unacknowledged completion is pending.

A flag is never cleared by a single access. Software must first read the status register while the flag reads 1, which arms that flag. It must then make the completing access. For the completion and collision flags this is a data-register read or write. For the mode-fault flag it is a control-register write. Each flag runs its own small state machine with three states:
- `FL_IDLE`: the flag reads 0.
- `FL_PEND`: the flag reads 1 and is not armed.
- `FL_ARMED`: the flag reads 1 and the status read has been seen.

The transitions are:
- set event: `FL_IDLE`→`FL_PEND`, and also `FL_ARMED`→`FL_PEND`.
- status read: `FL_PEND`→`FL_ARMED`.
- completing access: `FL_ARMED`→`FL_IDLE`.
- aborting access (any other register access): `FL_ARMED`→`FL_PEND`.
- status read again: `FL_ARMED`→`FL_ARMED`.

The slave-select input passes through a synchronizer with `SYNC_STAGES` flops before it is used.

Top module: `spi_stat_flags`

## Requirements
- R1: After reset the status byte is 00h. Transfer complete is bit 7, write collision is bit 6 and mode fault is bit 4. Bits 5 and 3:0 always read 0.
- R2: A `xfer_done` pulse sets bit 7 at the next clock edge.
- R3: Bit 7 clears at the edge after a data read or data write, provided that access is preceded by a status read taken while bit 7 was 1. Further status reads between the two steps keep the arm.
- R4: `wr_inhibit` is 1 in every cycle in which bit 7 is 1. This includes the data write that completes the clear.
- R5: A `data_wr` with `xfer_busy` high sets bit 6 at the next edge. Bit 6 clears by the same sequence as bit 7.
- R6: With `master_en`=1, a low `ss_n` sets bit 4 after SYNC_STAGES+1 edges. With `master_en`=0, bit 4 is never set.
- R7: Bit 4 clears only when a status read taken while bit 4 was 1 is followed by a `ctrl_wr`. Data accesses never clear it.
- R8: `irq` is 1 exactly when `irq_en` is 1 and bit 7 or bit 4 is 1. Bit 6 does not raise `irq`.
- R9: A status read arms only the flags that read 1 during that read. A flag set after the read is not cleared by the following completing access.
- R10: An arm is lost if an aborting access comes first. For bits 7 and 6 the aborting access is `ctrl_wr`. For bit 4 it is `data_rd` or `data_wr`.
- R11: If a set event and a completing access fall in the same cycle, the flag stays 1 and its arm is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| ctrl_wr | input | 1 | Control register write strobe |
| xfer_done | input | 1 | Transfer-finished pulse from shift engine |
| xfer_busy | input | 1 | Transfer-in-progress level from shift engine |
| master_en | input | 1 | Peripheral configured as master |
| ss_n | input | 1 | Asynchronous slave-select pin, active low |
| irq_en | input | 1 | Interrupt enable bit |
| status | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |
| wr_inhibit | output | 1 | Blocks the data register load |

## Verification
The case that is hardest to reach from the ports is a flag that collects a new set event while it is already armed. That event must cancel the pending acknowledgement, so a later completing access finds the flag still set. The bench reaches this case by arming the completion flag with a status read. It then drives a `xfer_done` pulse in the same cycle as the data read, and follows with a lone data read that must leave the flag at 1. A similar situation arises for the mode fault. A status read or control write made while `ss_n` is still low is defeated by the continuing set condition. The bench therefore releases `ss_n` and waits out the synchronizer before it runs the clearing sequence.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_PEND  = 2'd1,
        FL_ARMED = 2'd2
    } flag_st_t;

    localparam int STAT_W    = 8;
    localparam int NFLAGS    = 3;
    localparam int BIT_DONE  = 7;
    localparam int BIT_COLL  = 6;
    localparam int BIT_FAULT = 4;
    // flag slot indices
    localparam int F_DONE  = 0;
    localparam int F_COLL  = 1;
    localparam int F_FAULT = 2;
endpackage

// File: rtl/spi_flag_fsm.sv
module spi_flag_fsm
    import spi_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic stat_acc,
    input  logic clr_acc,
    input  logic abort_acc,
    output logic flag
);
    flag_st_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FL_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FL_IDLE: begin
                if (set_ev) st_d = FL_PEND;
            end
            FL_PEND: begin
                // the read saw a 1, so it arms even if a new set arrives
                if (stat_acc) st_d = FL_ARMED;
            end
            FL_ARMED: begin
                if (set_ev)         st_d = FL_PEND;
                else if (clr_acc)   st_d = FL_IDLE;
                else if (abort_acc) st_d = FL_PEND;
                else                st_d = FL_ARMED;
            end
            default: st_d = FL_IDLE;
        endcase
    end

    always_comb begin
        flag = (st_q != FL_IDLE);
    end
endmodule

// File: rtl/spi_ss_sync.sv
module spi_ss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q_out = d_in;
        end else begin : g_chain
            logic [STAGES-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '1;
                end else begin
                    q[0] <= d_in;
                    for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
                end
            end
            assign q_out = q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/spi_stat_flags.sv
module spi_stat_flags
    import spi_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic              ctrl_wr,
    input  logic              xfer_done,
    input  logic              xfer_busy,
    input  logic              master_en,
    input  logic              ss_n,
    input  logic              irq_en,
    output logic [STAT_W-1:0] status,
    output logic              irq,
    output logic              wr_inhibit
);
    logic              ss_q;
    logic              data_acc;
    logic [NFLAGS-1:0] set_v, clr_v, abort_v, flag_v;

    spi_ss_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (ss_n),
        .q_out (ss_q)
    );

    always_comb begin
        data_acc         = data_rd | data_wr;
        set_v[F_DONE]    = xfer_done;
        clr_v[F_DONE]    = data_acc;
        abort_v[F_DONE]  = ctrl_wr;
        set_v[F_COLL]    = data_wr & xfer_busy;
        clr_v[F_COLL]    = data_acc;
        abort_v[F_COLL]  = ctrl_wr;
        set_v[F_FAULT]   = master_en & ~ss_q;
        clr_v[F_FAULT]   = ctrl_wr;
        abort_v[F_FAULT] = data_acc;
    end

    generate
        for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
            spi_flag_fsm u_fl (
                .clk       (clk),
                .rst_n     (rst_n),
                .set_ev    (set_v[g]),
                .stat_acc  (stat_rd),
                .clr_acc   (clr_v[g]),
                .abort_acc (abort_v[g]),
                .flag      (flag_v[g])
            );
        end
    endgenerate

    always_comb begin
        status            = '0;
        status[BIT_DONE]  = flag_v[F_DONE];
        status[BIT_COLL]  = flag_v[F_COLL];
        status[BIT_FAULT] = flag_v[F_FAULT];
        irq               = irq_en & (flag_v[F_DONE] | flag_v[F_FAULT]);
        wr_inhibit        = flag_v[F_DONE];
    end
endmodule

// File: rtl/spi_stat_chk.sv
module spi_stat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stat_rd,
    input logic       data_rd,
    input logic       data_wr,
    input logic       ctrl_wr,
    input logic       xfer_done,
    input logic       xfer_busy,
    input logic       irq_en,
    input logic [7:0] status,
    input logic       irq,
    input logic       wr_inhibit
);
    p_spif_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> status[7]);
    p_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status[7] |-> wr_inhibit);
    p_spif_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[7]) |-> $past(data_rd | data_wr));
    p_wcol_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && xfer_busy) |=> status[6]);
    p_modf_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[4]) |-> $past(ctrl_wr));
    p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && (status[7] || status[4])) |-> irq);
    p_unused_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] == 1'b0) && (status[3:0] == 4'd0));
endmodule

bind spi_stat_flags spi_stat_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_rd    (stat_rd),
    .data_rd    (data_rd),
    .data_wr    (data_wr),
    .ctrl_wr    (ctrl_wr),
    .xfer_done  (xfer_done),
    .xfer_busy  (xfer_busy),
    .irq_en     (irq_en),
    .status     (status),
    .irq        (irq),
    .wr_inhibit (wr_inhibit)
);

// File: tb/sim_spi_stat_flags.sv
module sim_spi_stat_flags;
    logic clk = 1'b0, rst_n = 1'b0;
    logic stat_rd = 0, data_rd = 0, data_wr = 0, ctrl_wr = 0;
    logic xfer_done = 0, xfer_busy = 0, master_en = 0, ss_n = 1, irq_en = 0;
    logic [7:0] status;
    logic irq, wr_inhibit;
    int errors = 0, checks = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    spi_stat_flags #(.SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_rd(data_rd),
        .data_wr(data_wr), .ctrl_wr(ctrl_wr), .xfer_done(xfer_done),
        .xfer_busy(xfer_busy), .master_en(master_en), .ss_n(ss_n),
        .irq_en(irq_en), .status(status), .irq(irq), .wr_inhibit(wr_inhibit)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // one cycle of bus/engine activity; returns after the edge has taken effect
    task automatic cyc(input logic sr, input logic dr, input logic dw,
                       input logic cw, input logic dn);
        @(negedge clk);
        stat_rd = sr; data_rd = dr; data_wr = dw; ctrl_wr = cw; xfer_done = dn;
        @(negedge clk);
        stat_rd = 0; data_rd = 0; data_wr = 0; ctrl_wr = 0; xfer_done = 0;
    endtask

    task automatic t_reset;
        chk("R1 reset status", status, 8'h00);
        chk("R8 reset irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_spif_basic;
        cyc(0,0,0,0,1);
        chk("R2 done sets bit7", status, 8'h80);
        chk("R4 inhibit while set", {7'd0, wr_inhibit}, 8'h01);
        cyc(1,0,0,0,0);
        cyc(1,0,0,0,0);      // repeated status read keeps arm
        chk("R3 still set after status reads", status, 8'h80);
        @(negedge clk); data_wr = 1;
        #1 chk("R4 inhibit on clearing write", {7'd0, wr_inhibit}, 8'h01);
        @(negedge clk); data_wr = 0;
        chk("R3 cleared by data write", status, 8'h00);
        chk("R4 inhibit released", {7'd0, wr_inhibit}, 8'h00);
        cyc(0,0,0,0,1);
        cyc(1,0,0,0,0);
        cyc(0,1,0,0,0);
        chk("R3 cleared by data read", status, 8'h00);
    endtask

    task automatic t_wcol;
        xfer_busy = 1;
        cyc(0,0,1,0,0);
        xfer_busy = 0;
        chk("R5 collision set", status, 8'h40);
        chk("R8 collision no irq", {7'd0, irq}, 8'h00);
        cyc(1,0,0,0,0);
        cyc(0,1,0,0,0);
        chk("R5 collision cleared", status, 8'h00);
    endtask

    task automatic t_modf;
        master_en = 1;
        @(negedge clk); ss_n = 0;
        @(negedge clk); @(negedge clk);
        chk("R6 not yet after 2 edges", status, 8'h00);
        @(negedge clk);
        chk("R6 fault after 3 edges", status, 8'h10);
        ss_n = 1;
        repeat (3) @(negedge clk);
        cyc(1,0,0,0,0);
        cyc(0,1,0,0,0);      // data access aborts arm
        cyc(0,0,1,0,0);
        chk("R7 R10 data access no clear", status, 8'h10);
        cyc(0,0,0,1,0);      // no arm now
        chk("R7 ctrl write without arm", status, 8'h10);
        cyc(1,0,0,0,0);
        cyc(0,0,0,1,0);
        chk("R7 fault cleared", status, 8'h00);
        master_en = 0;
        ss_n = 0;
        repeat (5) @(negedge clk);
        chk("R6 slave mode no fault", status, 8'h00);
        ss_n = 1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_irq;
        irq_en = 0;
        cyc(0,0,0,0,1);
        chk("R8 irq masked", {7'd0, irq}, 8'h00);
        irq_en = 1;
        #1 chk("R8 irq from bit7", {7'd0, irq}, 8'h01);
        cyc(1,0,0,0,0);
        cyc(0,1,0,0,0);
        chk("R8 irq drops", {7'd0, irq}, 8'h00);
        irq_en = 0;
    endtask

    task automatic t_arm_rules;
        cyc(1,0,0,0,0);      // status read with bit7 = 0
        cyc(0,0,0,0,1);
        cyc(0,1,0,0,0);
        chk("R9 stale read does not arm", status, 8'h80);
        cyc(1,0,0,0,0);
        cyc(0,0,0,1,0);      // control write aborts
        cyc(0,1,0,0,0);
        chk("R10 arm lost after ctrl write", status, 8'h80);
        cyc(1,0,0,0,0);
        cyc(0,1,0,0,1);      // set and clear together
        chk("R11 set wins", status, 8'h80);
        cyc(0,1,0,0,0);
        chk("R11 arm dropped", status, 8'h80);
        cyc(1,0,0,0,0);
        cyc(0,1,0,0,0);
        chk("R3 final clear", status, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_spif_basic();
        t_wcol();
        t_modf();
        t_irq();
        t_arm_rules();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule